// File: doc/BRIEF.md
# Dual-Output PWM Generator with Edge Delays and Trip Protection

This block drives two PWM outputs from an up-counting time base whose period and compare thresholds are set through configuration inputs. The two outputs can be driven independently, each by its own compare threshold. They can also be driven as a complementary pair derived from the first threshold. In complementary mode a dead-band stage holds back the rising edge of each output by its own programmable number of clock cycles, so the two switches are never on together.

A protection input forces both outputs low at once. In latched mode the forced state persists until a clear strobe arrives. In per-cycle mode it lasts to the end of the current PWM period and releases at the counter wrap if the protection input has gone away. Period and threshold changes are shadowed: they take effect at the start of the next PWM period, so a running pulse is never cut short by a write.

Top module: `pwm_db_trip`

## Requirements
- R1: While rst_n is low both outputs are low whatever the configuration. The first clock after release sees the counter at zero.
- R2: The time base counts 0,1,...,P and then returns to 0, where P is the active period. The counter value reaching P is the wrap cycle.
- R3: cfg_period, cfg_cmp_a and cfg_cmp_b are captured only at the wrap edge and apply from the following zero count. Changes made mid-period do not alter the period in progress.
- R4: In independent mode (cfg_pair_comp=0), pwm_a is high one clock after a cycle whose count is below the active A threshold. pwm_b does the same against the B threshold.
- R5: In complementary mode (cfg_pair_comp=1), the reference is A's raw level delayed by one clock. pwm_a is high only after the reference has been high for at least cfg_rise_dly clocks. pwm_b is high only after it has been low for at least cfg_fall_dly clocks. The two outputs are never high together.
- R6: With both delays at zero in complementary mode, pwm_b is the exact inverse of pwm_a.
- R7: In per-cycle trip mode (cfg_trip_latch=0), trip_in high sets a trip state. The state holds both outputs low and clears only at a wrap edge at which trip_in is low.
- R8: In latched trip mode (cfg_trip_latch=1), trip_in high sets a trip state. The state holds both outputs low until a trip_clr strobe and ignores counter wraps.
- R9: When trip_clr and trip_in are high in the same cycle, the latched trip stays set.
- R10: trip_in high forces both outputs low in the same cycle, without waiting for a clock edge.
- R11: An A threshold of 0 keeps pwm_a low in independent mode. A threshold above the period keeps it high for the whole period.
- R12: A dead-band delay longer than the pulse it applies to suppresses that output for the pulse. The delay counter saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Period value P (shadowed) |
| cfg_cmp_a | input | CNT_W | Threshold for output A (shadowed) |
| cfg_cmp_b | input | CNT_W | Threshold for output B in independent mode (shadowed) |
| cfg_pair_comp | input | 1 | 1 = complementary pair, 0 = independent outputs |
| cfg_rise_dly | input | DB_W | Delay in clocks before pwm_a rises |
| cfg_fall_dly | input | DB_W | Delay in clocks before pwm_b rises after A's reference falls |
| cfg_trip_latch | input | 1 | 1 = latched trip, 0 = per-cycle trip |
| trip_in | input | 1 | Protection input, active high |
| trip_clr | input | 1 | Clears a latched trip |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The critical coincidence is a protection event that lands on the wrap cycle. In that cycle the per-cycle trip is both being released and being set, and the shadow values load at the same edge. The bench uses its own model's counter to place trip_in exactly on the wrap cycle, and also to drop it exactly there. It then judges, clock by clock, whether the outputs stay low through the whole next period or come back from zero. A second overlap is a trip releasing while the dead-band delay is still counting. Here the comparison on every clock shows whether the delay restarts from the reference edge, not from the trip release.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic {PAIR_INDEP = 1'b0, PAIR_COMP = 1'b1} pair_mode_e;
   typedef enum logic {TRIP_CYCLE = 1'b0, TRIP_HOLD = 1'b1} trip_mode_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] sh_period,
   input  logic [CNT_W-1:0] sh_cmp_a,
   input  logic [CNT_W-1:0] sh_cmp_b,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per_act,
   output logic             wrap,
   output logic             raw_a,
   output logic             raw_b
);
   logic [CNT_W-1:0] cnt_q, per_q, ca_q, cb_q;

   assign wrap = (cnt_q == per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         ca_q  <= '0;
         cb_q  <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
         per_q <= sh_period;
         ca_q  <= sh_cmp_a;
         cb_q  <= sh_cmp_b;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign raw_a   = (cnt_q < ca_q);
   assign raw_b   = (cnt_q < cb_q);
   assign cnt     = cnt_q;
   assign per_act = per_q;
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
   parameter int DB_W  = 8,
   parameter bit DB_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw_a,
   input  logic            raw_b,
   input  logic            comp_mode,
   input  logic [DB_W-1:0] rise_dly,
   input  logic [DB_W-1:0] fall_dly,
   output logic            pre_a,
   output logic            pre_b
);
   import pwm_pkg::*;

   logic            a_q, b_q;
   logic [DB_W-1:0] age_q;
   logic            comp_a, comp_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= 1'b0;
         b_q   <= 1'b0;
         age_q <= '0;
      end else begin
         a_q <= raw_a;
         b_q <= raw_b;
         if (raw_a != a_q)
            age_q <= '0;
         else if (age_q != {DB_W{1'b1}})
            age_q <= age_q + 1'b1;
      end
   end

   if (DB_EN) begin : g_db
      assign comp_a = a_q  && (age_q >= rise_dly);
      assign comp_b = !a_q && (age_q >= fall_dly);
   end else begin : g_nodb
      assign comp_a = a_q;
      assign comp_b = !a_q;
   end

   always_comb begin
      if (pair_mode_e'(comp_mode) == PAIR_COMP) begin
         pre_a = comp_a;
         pre_b = comp_b;
      end else begin
         pre_a = a_q;
         pre_b = b_q;
      end
   end
endmodule

// File: rtl/pwm_trip.sv
module pwm_trip (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_in,
   input  logic trip_clr,
   input  logic latch_mode,
   input  logic wrap,
   output logic hold_q,
   output logic cyc_q,
   output logic force_safe
);
   import pwm_pkg::*;

   logic hold_set, cyc_set;

   assign hold_set = trip_in && (trip_mode_e'(latch_mode) == TRIP_HOLD);
   assign cyc_set  = trip_in && (trip_mode_e'(latch_mode) == TRIP_CYCLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         cyc_q  <= 1'b0;
      end else begin
         hold_q <= hold_set || (hold_q && !trip_clr);
         cyc_q  <= cyc_set  || (cyc_q  && !wrap);
      end
   end

   assign force_safe = trip_in || hold_q || cyc_q;
endmodule

// File: rtl/pwm_db_trip.sv
module pwm_db_trip #(
   parameter int CNT_W = 16,
   parameter int DB_W  = 8,
   parameter bit DB_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_cmp_a,
   input  logic [CNT_W-1:0] cfg_cmp_b,
   input  logic             cfg_pair_comp,
   input  logic [DB_W-1:0]  cfg_rise_dly,
   input  logic [DB_W-1:0]  cfg_fall_dly,
   input  logic             cfg_trip_latch,
   input  logic             trip_in,
   input  logic             trip_clr,
   output logic             pwm_a,
   output logic             pwm_b
);
   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (DB_W >= 1 && DB_W <= 16)   else $error("DB_W out of range");
   end

   logic [CNT_W-1:0] cnt, per_act;
   logic             wrap, raw_a, raw_b, pre_a, pre_b;
   logic             hold_q, cyc_q, force_safe;

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n),
      .sh_period(cfg_period), .sh_cmp_a(cfg_cmp_a), .sh_cmp_b(cfg_cmp_b),
      .cnt(cnt), .per_act(per_act), .wrap(wrap), .raw_a(raw_a), .raw_b(raw_b)
   );

   pwm_deadband #(.DB_W(DB_W), .DB_EN(DB_EN)) u_db (
      .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
      .comp_mode(cfg_pair_comp), .rise_dly(cfg_rise_dly), .fall_dly(cfg_fall_dly),
      .pre_a(pre_a), .pre_b(pre_b)
   );

   pwm_trip u_trip (
      .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .trip_clr(trip_clr),
      .latch_mode(cfg_trip_latch), .wrap(wrap),
      .hold_q(hold_q), .cyc_q(cyc_q), .force_safe(force_safe)
   );

   assign pwm_a = rst_n && pre_a && !force_safe;
   assign pwm_b = rst_n && pre_b && !force_safe;
endmodule

// File: rtl/pwm_db_trip_chk.sv
module pwm_db_trip_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per_act,
   input logic             wrap,
   input logic             cfg_pair_comp,
   input logic             cfg_trip_latch,
   input logic             trip_in,
   input logic             cyc_q,
   input logic             pwm_a,
   input logic             pwm_b
);
   // R2: the counter never passes the active period
   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);

   // R3: the active period changes only at a wrap
   a_r3_period_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(per_act));

   // R5: complementary outputs never overlap
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pair_comp |-> !(pwm_a && pwm_b));

   // R7: per-cycle trip persists until a wrap
   a_r7_cycle_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q && !wrap) |=> cyc_q);

   // R8: latched trip keeps outputs low in the next cycle
   a_r8_latched_safe: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_in && cfg_trip_latch) |=> (!pwm_a && !pwm_b));

   // R10: trip input gates outputs in the same cycle
   a_r10_trip_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      trip_in |-> (!pwm_a && !pwm_b));
endmodule

bind pwm_db_trip pwm_db_trip_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .per_act(per_act), .wrap(wrap),
   .cfg_pair_comp(cfg_pair_comp), .cfg_trip_latch(cfg_trip_latch),
   .trip_in(trip_in), .cyc_q(cyc_q), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/tb_pwm_db_trip.sv
`timescale 1ns/1ps
module tb_pwm_db_trip;
   localparam int CNT_W = 16;
   localparam int DB_W  = 8;
   localparam int AGE_MAX = (1 << DB_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] cfg_period = '0, cfg_cmp_a = '0, cfg_cmp_b = '0;
   logic cfg_pair_comp = 1'b1;
   logic [DB_W-1:0] cfg_rise_dly = '0, cfg_fall_dly = '0;
   logic cfg_trip_latch = 1'b0, trip_in = 1'b0, trip_clr = 1'b0;
   logic pwm_a, pwm_b;

   always #5 clk = ~clk;

   pwm_db_trip #(.CNT_W(CNT_W), .DB_W(DB_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_cmp_a(cfg_cmp_a),
      .cfg_cmp_b(cfg_cmp_b), .cfg_pair_comp(cfg_pair_comp),
      .cfg_rise_dly(cfg_rise_dly), .cfg_fall_dly(cfg_fall_dly),
      .cfg_trip_latch(cfg_trip_latch), .trip_in(trip_in), .trip_clr(trip_clr),
      .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   int n_cmp = 0, n_bad = 0;
   string tag = "R1";
   bit done = 0;

   // behavioural reference state
   int m_cnt = 0, m_per = 0, m_ca = 0, m_cb = 0, m_age = 0;
   bit m_ref = 0, m_bq = 0, m_hold = 0, m_cyc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 0; m_ca = 0; m_cb = 0; m_age = 0;
         m_ref = 0; m_bq = 0; m_hold = 0; m_cyc = 0;
      end else begin
         bit ra, rb, wr;
         wr = (m_cnt == m_per);
         ra = (m_cnt < m_ca);
         rb = (m_cnt < m_cb);
         if (ra != m_ref) m_age = 0;
         else if (m_age < AGE_MAX) m_age = m_age + 1;
         m_ref = ra;
         m_bq  = rb;
         m_hold = (trip_in && cfg_trip_latch) || (m_hold && !trip_clr);
         m_cyc  = (trip_in && !cfg_trip_latch) || (m_cyc && !wr);
         if (wr) begin
            m_cnt = 0; m_per = int'(cfg_period);
            m_ca = int'(cfg_cmp_a); m_cb = int'(cfg_cmp_b);
         end else m_cnt = m_cnt + 1;
      end
   end

   task automatic check(string what, logic act, bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit pa, pb, ea, eb, fs;
         if (cfg_pair_comp) begin
            pa = m_ref && (m_age >= int'(cfg_rise_dly));
            pb = !m_ref && (m_age >= int'(cfg_fall_dly));
         end else begin
            pa = m_ref;
            pb = m_bq;
         end
         fs = trip_in || m_hold || m_cyc;
         ea = rst_n && pa && !fs;
         eb = rst_n && pb && !fs;
         check("pwm_a", pwm_a, ea);
         check("pwm_b", pwm_b, eb);
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic to_wrap();
      do step(1); while (m_cnt != m_per);
   endtask

   initial begin
      // R1: reset with a config that would otherwise drive pwm_b high
      tag = "R1"; step(3);
      rst_n = 1'b1;
      cfg_pair_comp = 1'b0;
      // R2/R4: independent outputs
      tag = "R4"; cfg_period = 9; cfg_cmp_a = 4; cfg_cmp_b = 7; step(35);
      // R3: mid-period writes apply only from the next zero
      tag = "R3"; step(3); cfg_cmp_a = 6; cfg_period = 5; step(2); cfg_cmp_a = 1; step(30);
      // R11: extreme thresholds
      tag = "R11"; cfg_cmp_a = 0; step(20); cfg_cmp_a = 12; step(25);
      // R5: complementary with separate delays
      tag = "R5"; cfg_pair_comp = 1'b1; cfg_period = 11; cfg_cmp_a = 6;
      cfg_rise_dly = 2; cfg_fall_dly = 3; step(40);
      // R6: zero delays
      tag = "R6"; cfg_rise_dly = 0; cfg_fall_dly = 0; step(30);
      // R12: delay longer than the pulse
      tag = "R12"; cfg_rise_dly = 20; cfg_fall_dly = 3; step(40);
      cfg_rise_dly = 2;
      // R7: per-cycle trip, short pulse then long
      tag = "R7"; cfg_trip_latch = 1'b0; step(5); trip_in = 1; step(2); trip_in = 0; step(30);
      trip_in = 1; step(30); trip_in = 0; step(30);
      // R7: trip placed on the wrap cycle, and dropped on the wrap cycle
      to_wrap(); trip_in = 1; step(1); trip_in = 0; step(30);
      trip_in = 1; step(4); to_wrap(); trip_in = 0; step(30);
      // R10: one-cycle trip pulse in latched mode is immediate
      tag = "R10"; cfg_trip_latch = 1'b1; step(3); trip_in = 1; step(1); trip_in = 0;
      // R8: latched trip holds through wraps until cleared
      tag = "R8"; step(30); trip_clr = 1; step(1); trip_clr = 0; step(30);
      // R9: clear coinciding with trip
      tag = "R9"; trip_in = 1; trip_clr = 1; step(2); trip_in = 0; trip_clr = 0; step(15);
      trip_clr = 1; step(1); trip_clr = 0; step(30);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired in %s actual=running expected=finished", tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule